// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Almost-Empty and Almost-Full Flags

This block is a first-in, first-out buffer for 9-bit words. It has a write side clocked by `wclk` and a read side clocked by `rclk`. The two clocks may be the same net or unrelated. The write and read pointers are kept as Gray codes and pass between the domains through multi-flop synchronizers. Each side computes its own flags from its own pointer and the synchronized copy of the other side's pointer. A flag may therefore be late to release, but it never releases early. All four flags are registered and active low.

Two offsets set the almost-empty and almost-full thresholds, each with single-word granularity. After reset both offsets are 7. Software writes the offsets through the data input while the shared enable/load pin `wen2_ld` is held low. It reads them back on the data output with the normal read enables while the same pin stays low. Each offset is split into a low part and a high part, so there are four slots in all. Loading and read-back each step through the four slots in a fixed order, each with its own pointer, and both wrap around.

The output register drives `dout` only while `oe_n` is low. Otherwise the output is released to high impedance. The depth is a parameter and must be a power of two. The depth, the data width and the synchronizer length are checked at elaboration.

Top module: `afifo_pflag`

## Requirements
- R1: After reset, `empty_n`=0, `pae_n`=0, `full_n`=1 and `paf_n`=1. Both offsets are 7, so the first four read-back words are 7, 0, 7, 0. The output register is 0.
- R2: Each rising `wclk` edge with `wen1_n`=0, `wen2_ld`=1 and `full_n`=1 stores `din`. Holding these conditions stores one word per cycle, and words are read out in the order they were written.
- R3: `full_n` goes low on the write edge that makes the stored count equal to DEPTH (512 by default). A write attempted while `full_n`=0 changes nothing: no stored word is overwritten and no extra word appears.
- R4: Each rising `rclk` edge with `ren1_n`=0, `ren2_n`=0, `empty_n`=1 and program mode off loads the oldest word into the output register, one word per cycle. A read attempted while `empty_n`=0 leaves the output register unchanged. `empty_n` goes low on the read edge that takes the last word.
- R5: `paf_n` is low when the stored count is at least DEPTH minus the full offset, and high when the number of free locations exceeds the full offset.
- R6: `pae_n` is low when the stored count is at most the empty offset, and high when the count exceeds it.
- R7: A `wclk` edge with `wen1_n`=0 and `wen2_ld`=0 writes `din` into an offset slot instead of the FIFO. The slots are taken in the order empty-offset low part (offset bits 4:0 from `din[4:0]`), empty-offset high part (offset bits 8:5 from `din[3:0]`), full-offset low part, full-offset high part, and the order then wraps to the first slot.
- R8: While `wen2_ld` is held low (program mode, seen by the read side after synchronization), a read-enable edge places the next offset slot, zero-extended, in the output register instead of reading the FIFO. Read-back uses its own pointer, follows the same slot order as loading and wraps.
- R9: With `oe_n`=1 the `dout` port is released (high impedance). With `oe_n`=0 it shows the output register.
- R10: `empty_n` and `pae_n` are updated on the read edge itself and release only after the write pointer has crossed the synchronizer. `full_n` and `paf_n` are updated on the write edge itself and release only after the read pointer has crossed the synchronizer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous reset, active low, for both domains |
| din | input | 9 | Write data, also the offset load value |
| wen1_n | input | 1 | Primary write enable, active low |
| wen2_ld | input | 1 | High: second write enable; low: offset load / program mode |
| ren1_n | input | 1 | Read enable one, active low |
| ren2_n | input | 1 | Read enable two, active low |
| oe_n | input | 1 | Output enable, active low; high releases `dout` |
| dout | output | 9 | Read data or offset read-back |
| empty_n | output | 1 | Empty flag, low when empty |
| pae_n | output | 1 | Almost-empty flag, low at or below the empty offset |
| paf_n | output | 1 | Almost-full flag, low at or above DEPTH minus the full offset |
| full_n | output | 1 | Full flag, low when full |

## Verification
The assertions assume that `wen2_ld` changes only while the read side is idle, and that both offsets stay fixed while the FIFO holds data. Offsets cross from the write domain to the read domain as quasi-static values, without a synchronizer of their own. The stimulus keeps within these assumptions. It loads and reads back offsets only while the FIFO is empty. It waits several cycles after every change of `wen2_ld`, and it runs both ports on one tied clock, so every synchronizer delay is a fixed number of edges. The flag checks cover the exact threshold crossings and the late-release behaviour. The drain after a full condition shows that a write attempted while full never overwrote data.

// File: rtl/afp_pkg.sv
package afp_pkg;

   // Offset slot order; load and read-back both walk it and wrap.
   typedef enum logic [1:0] {
      SLOT_E_LO = 2'd0,
      SLOT_E_HI = 2'd1,
      SLOT_F_LO = 2'd2,
      SLOT_F_HI = 2'd3
   } ofs_slot_e;

   function automatic logic [31:0] to_gray(input logic [31:0] b);
      return b ^ (b >> 1);
   endfunction

   function automatic logic [31:0] from_gray(input logic [31:0] g);
      logic [31:0] b;
      b[31] = g[31];
      for (int i = 30; i >= 0; i--) b[i] = b[i+1] ^ g[i];
      return b;
   endfunction

endpackage

// File: rtl/afp_sync.sv
module afp_sync #(
   parameter int W        = 10,
   parameter int STAGES   = 2,
   parameter bit RST_ONES = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] st [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_st
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) st[s] <= {W{RST_ONES}};
            else        st[s] <= d;
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) st[s] <= {W{RST_ONES}};
            else        st[s] <= st[s-1];
      end
   end

   assign q = st[STAGES-1];
endmodule

// File: rtl/afp_wctl.sv
module afp_wctl
   import afp_pkg::*;
#(
   parameter int AW = 9
) (
   input  logic        wclk,
   input  logic        rst_n,
   input  logic        wr_req,
   input  logic [AW-1:0] fofs,
   input  logic [AW:0] rgray_s,
   output logic        wr_fire,
   output logic [AW:0] wbin,
   output logic [AW:0] wgray,
   output logic        full_n,
   output logic        paf_n
);
   localparam int PW = AW + 1;
   localparam logic [AW:0] DEPTH = {1'b1, {AW{1'b0}}};

   logic [AW:0] rbin_s, wbin_nx, cnt_nx;

   assign rbin_s  = PW'(from_gray(32'(rgray_s)));
   assign wr_fire = wr_req & full_n;
   assign wbin_nx = wbin + PW'(wr_fire);
   assign cnt_nx  = wbin_nx - rbin_s;

   always_ff @(posedge wclk or negedge rst_n)
      if (!rst_n) begin
         wbin   <= '0;
         wgray  <= '0;
         full_n <= 1'b1;
         paf_n  <= 1'b1;
      end else begin
         wbin   <= wbin_nx;
         wgray  <= PW'(to_gray(32'(wbin_nx)));
         full_n <= (cnt_nx != DEPTH);
         paf_n  <= (cnt_nx < (DEPTH - {1'b0, fofs}));
      end
endmodule

// File: rtl/afp_rctl.sv
module afp_rctl
   import afp_pkg::*;
#(
   parameter int AW = 9
) (
   input  logic        rclk,
   input  logic        rst_n,
   input  logic        rd_req,
   input  logic [AW-1:0] eofs,
   input  logic [AW:0] wgray_s,
   output logic        rd_fire,
   output logic [AW:0] rbin,
   output logic [AW:0] rgray,
   output logic        empty_n,
   output logic        pae_n
);
   localparam int PW = AW + 1;

   logic [AW:0] wbin_s, rbin_nx, cnt_nx;

   assign wbin_s  = PW'(from_gray(32'(wgray_s)));
   assign rd_fire = rd_req & empty_n;
   assign rbin_nx = rbin + PW'(rd_fire);
   assign cnt_nx  = wbin_s - rbin_nx;

   always_ff @(posedge rclk or negedge rst_n)
      if (!rst_n) begin
         rbin    <= '0;
         rgray   <= '0;
         empty_n <= 1'b0;
         pae_n   <= 1'b0;
      end else begin
         rbin    <= rbin_nx;
         rgray   <= PW'(to_gray(32'(rbin_nx)));
         empty_n <= (cnt_nx != '0);
         pae_n   <= (cnt_nx > {1'b0, eofs});
      end
endmodule

// File: rtl/afp_ofs.sv
module afp_ofs
   import afp_pkg::*;
#(
   parameter int AW   = 9,
   parameter int DW   = 9,
   parameter int LO_W = 5,
   parameter int DEF  = 7
) (
   input  logic            wclk,
   input  logic            rclk,
   input  logic            rst_n,
   input  logic            ld_req,
   input  logic [LO_W-1:0] ld_data,
   input  logic            rb_req,
   output logic [AW-1:0]   eofs,
   output logic [AW-1:0]   fofs,
   output logic [DW-1:0]   rb_data
);
   localparam int HI_W = AW - LO_W;

   ofs_slot_e ld_slot, rb_slot;

   always_ff @(posedge wclk or negedge rst_n)
      if (!rst_n) begin
         eofs    <= AW'(DEF);
         fofs    <= AW'(DEF);
         ld_slot <= SLOT_E_LO;
      end else if (ld_req) begin
         case (ld_slot)
            SLOT_E_LO: eofs[LO_W-1:0]  <= ld_data;
            SLOT_E_HI: eofs[AW-1:LO_W] <= ld_data[HI_W-1:0];
            SLOT_F_LO: fofs[LO_W-1:0]  <= ld_data;
            default:   fofs[AW-1:LO_W] <= ld_data[HI_W-1:0];
         endcase
         ld_slot <= ofs_slot_e'(2'(ld_slot) + 2'd1);
      end

   always_ff @(posedge rclk or negedge rst_n)
      if (!rst_n)      rb_slot <= SLOT_E_LO;
      else if (rb_req) rb_slot <= ofs_slot_e'(2'(rb_slot) + 2'd1);

   always_comb
      case (rb_slot)
         SLOT_E_LO: rb_data = DW'(eofs[LO_W-1:0]);
         SLOT_E_HI: rb_data = DW'(eofs[AW-1:LO_W]);
         SLOT_F_LO: rb_data = DW'(fofs[LO_W-1:0]);
         default:   rb_data = DW'(fofs[AW-1:LO_W]);
      endcase
endmodule

// File: rtl/afifo_pflag.sv
module afifo_pflag
   import afp_pkg::*;
#(
   parameter int DW          = 9,
   parameter int AW          = 9,
   parameter int DEF_OFS     = 7,
   parameter int SYNC_STAGES = 2
) (
   input  logic          wclk,
   input  logic          rclk,
   input  logic          rst_n,
   input  logic [DW-1:0] din,
   input  logic          wen1_n,
   input  logic          wen2_ld,
   input  logic          ren1_n,
   input  logic          ren2_n,
   input  logic          oe_n,
   output logic [DW-1:0] dout,
   output logic          empty_n,
   output logic          pae_n,
   output logic          paf_n,
   output logic          full_n
);
   localparam int DEPTH = 1 << AW;
   localparam int LO_W  = (AW + 1) / 2;

   if (AW < 2 || AW > 16) begin : g_bad_aw
      $error("afifo_pflag: AW must lie in 2..16");
   end
   if (DW < LO_W) begin : g_bad_dw
      $error("afifo_pflag: DW too narrow to carry an offset part");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("afifo_pflag: at least two synchronizer stages required");
   end
   if (DEF_OFS < 0 || DEF_OFS >= DEPTH) begin : g_bad_def
      $error("afifo_pflag: default offset out of range");
   end

   logic [AW:0]   wbin, wgray, rbin, rgray, wgray_s, rgray_s;
   logic [AW-1:0] eofs, fofs;
   logic [DW-1:0] rb_data, q;
   logic          wr_fire, rd_fire, prog_n, rd_any;

   logic [DW-1:0] mem [DEPTH];

   assign rd_any = ~ren1_n & ~ren2_n;

   afp_wctl #(.AW(AW)) wctl_i (
      .wclk(wclk), .rst_n(rst_n), .wr_req(~wen1_n & wen2_ld), .fofs(fofs),
      .rgray_s(rgray_s), .wr_fire(wr_fire), .wbin(wbin), .wgray(wgray),
      .full_n(full_n), .paf_n(paf_n));

   afp_rctl #(.AW(AW)) rctl_i (
      .rclk(rclk), .rst_n(rst_n), .rd_req(rd_any & prog_n), .eofs(eofs),
      .wgray_s(wgray_s), .rd_fire(rd_fire), .rbin(rbin), .rgray(rgray),
      .empty_n(empty_n), .pae_n(pae_n));

   afp_sync #(.W(AW+1), .STAGES(SYNC_STAGES), .RST_ONES(1'b0)) w2r_i (
      .clk(rclk), .rst_n(rst_n), .d(wgray), .q(wgray_s));

   afp_sync #(.W(AW+1), .STAGES(SYNC_STAGES), .RST_ONES(1'b0)) r2w_i (
      .clk(wclk), .rst_n(rst_n), .d(rgray), .q(rgray_s));

   afp_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_ONES(1'b1)) prog_i (
      .clk(rclk), .rst_n(rst_n), .d(wen2_ld), .q(prog_n));

   afp_ofs #(.AW(AW), .DW(DW), .LO_W(LO_W), .DEF(DEF_OFS)) ofs_i (
      .wclk(wclk), .rclk(rclk), .rst_n(rst_n),
      .ld_req(~wen1_n & ~wen2_ld), .ld_data(din[LO_W-1:0]),
      .rb_req(rd_any & ~prog_n), .eofs(eofs), .fofs(fofs), .rb_data(rb_data));

   always_ff @(posedge wclk)
      if (wr_fire) mem[wbin[AW-1:0]] <= din;

   always_ff @(posedge rclk or negedge rst_n)
      if (!rst_n)                q <= '0;
      else if (rd_fire)          q <= mem[rbin[AW-1:0]];
      else if (rd_any & ~prog_n) q <= rb_data;

   assign dout = oe_n ? {DW{1'bz}} : q;
endmodule

// File: rtl/afp_chk.sv
module afp_chk #(
   parameter int AW = 9
) (
   input logic        wclk,
   input logic        rclk,
   input logic        rst_n,
   input logic        wen1_n,
   input logic        wen2_ld,
   input logic        ren1_n,
   input logic        ren2_n,
   input logic        prog_n,
   input logic        full_n,
   input logic        paf_n,
   input logic        empty_n,
   input logic        pae_n,
   input logic [AW:0] wbin,
   input logic [AW:0] rbin
);
   p_write_advances_r2: assert property (@(posedge wclk) disable iff (!rst_n)
      (full_n && !wen1_n && wen2_ld) |=> (wbin == (AW+1)'($past(wbin) + 1'b1)));

   p_no_overflow_r3: assert property (@(posedge wclk) disable iff (!rst_n)
      (!full_n && !wen1_n && wen2_ld) |=> $stable(wbin));

   p_no_underflow_r4: assert property (@(posedge rclk) disable iff (!rst_n)
      (!empty_n && !ren1_n && !ren2_n) |=> $stable(rbin));

   p_full_implies_paf_r5: assert property (@(posedge wclk) disable iff (!rst_n)
      !full_n |-> !paf_n);

   p_empty_implies_pae_r6: assert property (@(posedge rclk) disable iff (!rst_n)
      !empty_n |-> !pae_n);

   p_load_not_stored_r7: assert property (@(posedge wclk) disable iff (!rst_n)
      (!wen1_n && !wen2_ld) |=> $stable(wbin));

   p_readback_not_popped_r8: assert property (@(posedge rclk) disable iff (!rst_n)
      (!prog_n && !ren1_n && !ren2_n) |=> $stable(rbin));
endmodule

bind afifo_pflag afp_chk #(.AW(AW)) chk_i (
   .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .wen1_n(wen1_n), .wen2_ld(wen2_ld),
   .ren1_n(ren1_n), .ren2_n(ren2_n), .prog_n(prog_n), .full_n(full_n),
   .paf_n(paf_n), .empty_n(empty_n), .pae_n(pae_n), .wbin(wbin), .rbin(rbin));

// File: tb/afifo_pflag_tb_top.sv
`timescale 1ns/1ps
module afifo_pflag_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int DEPTH      = 512;

   // {expected pae_n after reading this entry, data}
   localparam logic [9:0] VEC [16] = '{
      10'h200, 10'h3FF, 10'h355, 10'h2AA, 10'h201, 10'h300, 10'h2F0, 10'h30F,
      10'h033, 10'h1CC, 10'h07E, 10'h181, 10'h024, 10'h1DB, 10'h0C3, 10'h13C};

   logic clk = 1'b0, rst_n = 1'b0;
   logic [8:0] din = '0;
   logic wen1_n = 1'b1, wen2_ld = 1'b1, ren1_n = 1'b1, ren2_n = 1'b1, oe_n = 1'b1;
   wire  [8:0] dout;
   logic empty_n, pae_n, paf_n, full_n;
   int n_chk = 0, n_bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   for (genvar i = 0; i < 9; i++) begin : g_pu
      pullup (dout[i]);
   end

   afifo_pflag dut_i (
      .wclk(clk), .rclk(clk), .rst_n(rst_n), .din(din), .wen1_n(wen1_n),
      .wen2_ld(wen2_ld), .ren1_n(ren1_n), .ren2_n(ren2_n), .oe_n(oe_n),
      .dout(dout), .empty_n(empty_n), .pae_n(pae_n), .paf_n(paf_n), .full_n(full_n));

   task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic wr_word(input logic [8:0] v);
      @(negedge clk); din = v; wen1_n = 1'b0; wen2_ld = 1'b1;
      @(posedge clk); #1; wen1_n = 1'b1;
   endtask

   task automatic ld_word(input logic [8:0] v);
      @(negedge clk); din = v; wen1_n = 1'b0; wen2_ld = 1'b0;
      @(posedge clk); #1; wen1_n = 1'b1;
   endtask

   task automatic rd_word(output logic [8:0] v);
      @(negedge clk); ren1_n = 1'b0; ren2_n = 1'b0;
      @(posedge clk); #1; ren1_n = 1'b1; ren2_n = 1'b1;
      v = dout;
   endtask

   task automatic do_reset();
      @(negedge clk); rst_n = 1'b0;
      wait_cyc(3);
      @(negedge clk); rst_n = 1'b1;
      #1;
   endtask

   task automatic check_readback(input logic [8:0] e0, input logic [8:0] e1,
                                 input logic [8:0] e2, input logic [8:0] e3, input string tag);
      logic [8:0] v;
      logic [8:0] exp [4];
      exp = '{e0, e1, e2, e3};
      @(negedge clk); wen2_ld = 1'b0;
      wait_cyc(3);
      for (int i = 0; i < 4; i++) begin
         rd_word(v);
         check(32'(v), 32'(exp[i]), tag);
      end
      check(32'(empty_n), 0, {tag, " no FIFO pop"});
      @(negedge clk); wen2_ld = 1'b1;
      wait_cyc(3);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [8:0] v;
      do_reset();
      // R1 reset flags, R9 released output reads the pull-up value
      check(32'({empty_n, pae_n, full_n, paf_n}), 32'b0011, "R1 reset flags");
      check(32'(dout), 32'h1FF, "R9 oe_n=1 released");
      @(negedge clk); oe_n = 1'b0; #1;
      check(32'(dout), 32'h000, "R9 R1 output register after reset");
      check_readback(9'd7, 9'd0, 9'd7, 9'd0, "R1 R8 default offsets");

      // R2 R10: table of words, written back to back
      wr_word(VEC[0][8:0]);
      check(32'(empty_n), 0, "R10 empty_n not released early");
      for (int i = 1; i < 16; i++) wr_word(VEC[i][8:0]);
      wait_cyc(5);
      check(32'({empty_n, pae_n}), 32'b11, "R10 R6 flags released after sync");
      for (int i = 0; i < 16; i++) begin
         rd_word(v);
         check(32'(v), 32'(VEC[i][8:0]), "R2 R4 data order");
         check(32'(pae_n), 32'(VEC[i][9]), "R6 pae_n threshold 7");
      end
      check(32'(empty_n), 0, "R4 empty_n on last read");
      rd_word(v);
      check(32'(v), 32'(VEC[15][8:0]), "R4 read on empty ignored");

      // R5 R3: fill to full with the default full offset 7
      for (int k = 0; k < DEPTH - 8; k++) wr_word(9'(k));
      check(32'(paf_n), 1, "R5 paf_n high at 504 words");
      wr_word(9'(DEPTH - 8));
      check(32'(paf_n), 0, "R5 paf_n low at 505 words");
      for (int k = DEPTH - 7; k < DEPTH - 1; k++) wr_word(9'(k));
      check(32'(full_n), 1, "R3 full_n high at 511 words");
      wr_word(9'(DEPTH - 1));
      check(32'(full_n), 0, "R3 full_n low at 512 words");
      wr_word(9'h1AA);
      wait_cyc(5);
      rd_word(v);
      check(32'(v), 0, "R3 write while full ignored (first word)");
      check(32'(full_n), 0, "R10 full_n not released early");
      wait_cyc(5);
      check(32'(full_n), 1, "R10 full_n released after sync");
      for (int k = 1; k < DEPTH; k++) begin
         rd_word(v);
         check(32'(v), 32'(k), "R2 R3 drain order");
      end
      check(32'(empty_n), 0, "R3 no extra word after drain");

      // R7 R8: program offsets, then a fifth load wraps to the first slot
      ld_word(9'd3); ld_word(9'd0); ld_word(9'd2); ld_word(9'd0);
      ld_word(9'd4);
      check(32'(empty_n), 0, "R7 load does not enter FIFO");
      check_readback(9'd4, 9'd0, 9'd2, 9'd0, "R7 R8 programmed offsets");
      @(negedge clk); wen2_ld = 1'b0; wait_cyc(3);
      rd_word(v);
      check(32'(v), 32'd4, "R8 read-back pointer wraps");
      @(negedge clk); wen2_ld = 1'b1; wait_cyc(3);

      // R6 with empty offset 4, R5 with full offset 2
      for (int k = 0; k < 4; k++) wr_word(9'(k));
      wait_cyc(5);
      check(32'(pae_n), 0, "R6 pae_n low at 4 words, offset 4");
      wr_word(9'd4);
      wait_cyc(5);
      check(32'(pae_n), 1, "R6 pae_n high at 5 words, offset 4");
      for (int k = 5; k < DEPTH - 3; k++) wr_word(9'(k));
      check(32'(paf_n), 1, "R5 paf_n high at 509 words, offset 2");
      wr_word(9'h0AB);
      check(32'(paf_n), 0, "R5 paf_n low at 510 words, offset 2");
      check(32'(full_n), 1, "R3 not full at 510 words");

      // R1: reset while holding data restores flags and offsets
      do_reset();
      check(32'({empty_n, pae_n, full_n, paf_n}), 32'b0011, "R1 reset mid-run flags");
      check_readback(9'd7, 9'd0, 9'd7, 9'd0, "R1 offsets back to default");
      @(negedge clk); oe_n = 1'b1; #1;
      check(32'(dout), 32'h1FF, "R9 released again");

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule